// File: doc/BRIEF.md
# Memory-Mapped BCD Calendar Clock

This block keeps the time of day and the calendar in packed BCD counters and shows them to a host as eight byte registers. Those registers sit at the very top of a 13-bit, byte-wide address space. Every address below that window goes to a plain byte store. The host reads and writes the window with the same synchronous bus cycle it uses for memory. A one-pulse-per-second tick advances the counters. On that tick the visible clock bytes are refreshed from the counters, unless the control byte holds them.

The visible clock bytes are copies of the counters, not the counters themselves. The control byte at the bottom of the window has two uses. It can freeze the copies, so that software reads a coherent snapshot. It can also open them for writing; when it is closed again, the written bytes are loaded into the counters. A power-fail input blocks every host write, and time keeps running while it is asserted.

Top module: `bcd_rtc_mem`

## Requirements
- R1: Addresses 1FF8h..1FFFh form the clock window, at offsets 0 control, 1 seconds, 2 minutes, 3 hours, 4 day byte, 5 date, 6 month, 7 year. Every lower address reaches a byte store indexed by its low RAM_AW bits, with RAM_AW = 8 by default, so addresses alias every 256 bytes.
- R2: `dq_oe` is 1 and `dq_out` carries the addressed byte when `ce_n`=0, `we_n`=1 and `oe_n`=0. In every other case `dq_oe` is 0 and `dq_out` is 00h. In particular, `ce_n`=1 releases the bus whatever the other controls are.
- R3: A write takes place at the clock edge where `ce_n`=0 and `we_n`=0, whatever the level of `oe_n`, and it is visible on reads from the next cycle on.
- R4: While `pwr_fail`=1, no write changes the byte store, the control byte, the clock bytes or the counters. Ticks still advance the counters and refresh the clock bytes.
- R5: After reset the control byte reads 00h and the clock bytes read 00 seconds, 00 minutes, 00 hours, day byte 01h, date 01h, month 01h and year 00h. Seconds, minutes, hours, date, month and year are packed BCD.
- R6: Each tick adds one second. Seconds and minutes wrap 59 to 00, hours wrap 23 to 00, and the day of week (day byte bits 2:0) counts 1..7 and wraps 7 to 1 when the hours wrap.
- R7: The date wraps to 01 and the month advances after day 31 of months 1,3,5,7,8,10,12 and after day 30 of months 4,6,9,11. February ends on day 29 when the BCD year is divisible by 4, and on day 28 otherwise. The month wraps 12 to 01 and advances the year.
- R8: The year wraps 99 to 00 and then increments a 2-bit binary century held in day byte bits 7:6, which wraps 3 to 0. Day byte bits 5:3 read 0.
- R9: When control bits 7 and 6 are both 0, a tick cycle updates the clock bytes to the new counter values, and reads show them from the next cycle on.
- R10: While control bit 7 (freeze) is 1, ticks leave the clock bytes unchanged and the counters keep advancing. The next tick after the bit is cleared shows the fully advanced time.
- R11: Writes to clock bytes (offsets 1..7) take effect only while control bit 6 is 1, and refreshes are suspended while it is. A control write that changes bit 6 from 1 to 0 loads the clock bytes into the counters. A tick in that same cycle is dropped.
- R12: Control bits 5:0 hold a calibration value that is stored and read back unchanged and has no effect on timekeeping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| pwr_fail | input | 1 | High blocks all host writes |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| addr | input | 13 | Byte address |
| dq_in | input | 8 | Write data |
| dq_out | output | 8 | Read data, 00h when released |
| dq_oe | output | 1 | High while the block drives read data |

## Verification
On every cycle the assertions check these behaviours: a deselected bus is released, the control byte does not move under power fail, and a refresh copies the counters exactly. They also check that a freeze holds the copies, that a write-mode exit loads the counters, and that the seconds wrap. The calendar arithmetic itself is shown only by the bench's scenarios. These cover the month lengths, the leap-year February, the carry from year into century, the day-of-week wrap, and the dropping of a tick that coincides with a load. The bench's per-cycle model compares every read, so it also shows how the byte store aliases and that ignored writes really leave the stored values unchanged.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef struct packed {
    logic [1:0] cent;
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] date;
    logic [2:0] wday;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } rtc_time_t;

  localparam rtc_time_t RTC_RESET = '{cent: 2'd0, year: 8'h00, month: 8'h01,
                                      date: 8'h01, wday: 3'd1, hour: 8'h00,
                                      min: 8'h00, sec: 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic leap_bcd(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return leap_bcd(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic rtc_time_t time_next(input rtc_time_t t);
    rtc_time_t n = t;
    n.sec = bcd_inc(t.sec);
    if (t.sec == 8'h59) begin
      n.sec = 8'h00;
      n.min = bcd_inc(t.min);
      if (t.min == 8'h59) begin
        n.min  = 8'h00;
        n.hour = bcd_inc(t.hour);
        if (t.hour == 8'h23) begin
          n.hour = 8'h00;
          n.wday = (t.wday == 3'd7) ? 3'd1 : t.wday + 3'd1;
          n.date = bcd_inc(t.date);
          if (t.date == month_last(t.month, t.year)) begin
            n.date  = 8'h01;
            n.month = bcd_inc(t.month);
            if (t.month == 8'h12) begin
              n.month = 8'h01;
              n.year  = bcd_inc(t.year);
              if (t.year == 8'h99) begin
                n.year = 8'h00;
                n.cent = t.cent + 2'd1;
              end
            end
          end
        end
      end
    end
    return n;
  endfunction

  function automatic logic [7:0] win_get(input rtc_time_t t, input logic [2:0] off);
    case (off)
      3'd1:    return t.sec;
      3'd2:    return t.min;
      3'd3:    return t.hour;
      3'd4:    return {t.cent, 3'b000, t.wday};
      3'd5:    return t.date;
      3'd6:    return t.month;
      3'd7:    return t.year;
      default: return 8'h00;
    endcase
  endfunction

  function automatic rtc_time_t win_put(input rtc_time_t t, input logic [2:0] off,
                                        input logic [7:0] b);
    rtc_time_t n = t;
    case (off)
      3'd1: n.sec = b;
      3'd2: n.min = b;
      3'd3: n.hour = b;
      3'd4: begin n.cent = b[7:6]; n.wday = b[2:0]; end
      3'd5: n.date = b;
      3'd6: n.month = b;
      3'd7: n.year = b;
      default: ;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/rtc_counter.sv
module rtc_counter
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      load,
  input  rtc_time_t load_val,
  output rtc_time_t cnt,
  output rtc_time_t cnt_nxt
);
  assign cnt_nxt = time_next(cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= RTC_RESET;
    else if (load) cnt <= load_val;
    else if (tick) cnt <= cnt_nxt;
  end
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       win_we,
  input  logic [2:0] win_off,
  input  logic [7:0] wdata,
  input  logic       tick,
  input  rtc_time_t  cnt_nxt,
  output logic [7:0] ctrl,
  output rtc_time_t  mirror,
  output logic       refresh_en,
  output logic       load_en
);
  logic ctrl_we, clk_we;

  assign ctrl_we    = win_we && (win_off == 3'd0);
  assign clk_we     = win_we && (win_off != 3'd0) && ctrl[6];
  assign refresh_en = tick && !ctrl[7] && !ctrl[6];
  assign load_en    = ctrl_we && ctrl[6] && !wdata[6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= 8'h00;
      mirror <= RTC_RESET;
    end else begin
      if (ctrl_we)         ctrl   <= wdata;
      if (clk_we)          mirror <= win_put(mirror, win_off, wdata);
      else if (refresh_en) mirror <= cnt_nxt;
    end
  end
endmodule

// File: rtl/rtc_ram.sv
module rtc_ram #(
  parameter int AW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/bcd_rtc_mem.sv
module bcd_rtc_mem
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int RAM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              pwr_fail,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dq_in,
  output logic [7:0]        dq_out,
  output logic              dq_oe
);
  logic       wr_en, win_hit, ram_we, win_we, refresh_en, load_en;
  logic [2:0] win_off;
  logic [7:0] ctrl_q, ram_rd, win_rd;
  rtc_time_t  cnt_q, cnt_nxt, mirror_q;

  assign win_hit = &addr[ADDR_W-1:3];
  assign win_off = addr[2:0];
  assign wr_en   = !ce_n && !we_n && !pwr_fail;
  assign win_we  = wr_en && win_hit;
  assign ram_we  = wr_en && !win_hit;
  assign dq_oe   = !ce_n && we_n && !oe_n;
  assign win_rd  = (win_off == 3'd0) ? ctrl_q : win_get(mirror_q, win_off);
  assign dq_out  = !dq_oe ? 8'h00 : (win_hit ? win_rd : ram_rd);

  rtc_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .load(load_en),
    .load_val(mirror_q), .cnt(cnt_q), .cnt_nxt(cnt_nxt)
  );

  rtc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .win_we(win_we), .win_off(win_off),
    .wdata(dq_in), .tick(tick_1hz), .cnt_nxt(cnt_nxt), .ctrl(ctrl_q),
    .mirror(mirror_q), .refresh_en(refresh_en), .load_en(load_en)
  );

  rtc_ram #(.AW(RAM_AW)) u_ram (
    .clk(clk), .we(ram_we), .idx(addr[RAM_AW-1:0]), .wdata(dq_in), .rdata(ram_rd)
  );
endmodule

// File: rtl/rtc_chk.sv
module rtc_chk
  import rtc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       pwr_fail,
  input logic       tick_1hz,
  input logic       dq_oe,
  input logic [7:0] ctrl_q,
  input rtc_time_t  cnt_q,
  input rtc_time_t  mirror_q,
  input logic       refresh_en,
  input logic       load_en
);
  // R2
  bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !dq_oe);

  // R4
  pwrfail_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> $stable(ctrl_q));

  // R4
  pwrfail_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail && tick_1hz |=> cnt_q != $past(cnt_q));

  // R9
  refresh_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_en |=> mirror_q == cnt_q);

  // R10
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[7] && !ctrl_q[6] |=> $stable(mirror_q));

  // R11
  load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> cnt_q == $past(mirror_q));

  // R6
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1hz && !load_en && cnt_q.sec == 8'h59 |=> cnt_q.sec == 8'h00);
endmodule

bind bcd_rtc_mem rtc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .pwr_fail(pwr_fail),
  .tick_1hz(tick_1hz), .dq_oe(dq_oe), .ctrl_q(ctrl_q), .cnt_q(cnt_q),
  .mirror_q(mirror_q), .refresh_en(refresh_en), .load_en(load_en)
);

// File: tb/tb_bcd_rtc_mem.sv
module tb_bcd_rtc_mem;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 8184;

  logic clk = 0, rst_n = 0, tick_1hz = 0, pwr_fail = 0;
  logic ce_n = 1, oe_n = 1, we_n = 1;
  logic [12:0] addr = '0;
  logic [7:0]  dq_in = '0, dq_out;
  logic        dq_oe;

  int errors = 0, checks = 0;
  string cur_req = "R5";
  bit done = 0;

  // reference model state
  int m_sec, m_min, m_hour, m_wday, m_date, m_mon, m_year, m_cent;
  int ctrl;
  int mir[8];
  int ram[256];
  bit known[256];

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_rtc_mem dut (.clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .pwr_fail(pwr_fail),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe));

  function automatic int to_bcd(int n); return (n / 10) * 16 + n % 10; endfunction
  function automatic int from_bcd(int b); return (b / 16) * 10 + b % 16; endfunction

  function automatic int days_in(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic advance();
    m_sec++;
    if (m_sec < 60) return;
    m_sec = 0; m_min++;
    if (m_min < 60) return;
    m_min = 0; m_hour++;
    if (m_hour < 24) return;
    m_hour = 0;
    m_wday = (m_wday == 7) ? 1 : m_wday + 1;
    m_date++;
    if (m_date <= days_in(m_mon, m_year)) return;
    m_date = 1; m_mon++;
    if (m_mon < 13) return;
    m_mon = 1; m_year++;
    if (m_year < 100) return;
    m_year = 0; m_cent = (m_cent + 1) % 4;
  endtask

  task automatic publish();
    mir[1] = to_bcd(m_sec); mir[2] = to_bcd(m_min); mir[3] = to_bcd(m_hour);
    mir[4] = m_cent * 64 + m_wday; mir[5] = to_bcd(m_date);
    mir[6] = to_bcd(m_mon); mir[7] = to_bcd(m_year);
  endtask

  task automatic model_reset();
    m_sec = 0; m_min = 0; m_hour = 0; m_wday = 1; m_date = 1; m_mon = 1;
    m_year = 0; m_cent = 0; ctrl = 0;
    publish();
    foreach (known[i]) known[i] = 0;
  endtask

  task automatic model_step(bit c, bit w, int a, int d, bit tk, bit pf);
    int old = ctrl;
    bit load = 0;
    if (!c && !w && !pf) begin
      if (a >= WIN) begin
        if (a == WIN) begin
          load = old[6] && !d[6];
          ctrl = d;
        end else if (old[6]) mir[a - WIN] = (a - WIN == 4) ? (d & 8'hC7) : d;
      end else begin
        ram[a % 256] = d; known[a % 256] = 1;
      end
    end
    if (load) begin
      m_sec = from_bcd(mir[1]); m_min = from_bcd(mir[2]); m_hour = from_bcd(mir[3]);
      m_wday = mir[4] % 8; m_cent = mir[4] / 64; m_date = from_bcd(mir[5]);
      m_mon = from_bcd(mir[6]); m_year = from_bcd(mir[7]);
    end else if (tk) begin
      advance();
      if (!old[7] && !old[6]) publish();
    end
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: addr=%h actual=%h expected=%h", req, addr, act, exp);
    end
  endtask

  task automatic cyc(bit c, bit o, bit w, int a, int d, bit tk, bit pf);
    bit e_oe;
    int e_d;
    bit chk_d = 1;
    @(negedge clk);
    ce_n = c; oe_n = o; we_n = w; addr = a[12:0]; dq_in = d[7:0];
    tick_1hz = tk; pwr_fail = pf;
    #1;
    e_oe = !c && w && !o;
    e_d = 0;
    if (e_oe) begin
      if (a >= WIN) e_d = (a == WIN) ? ctrl : mir[a - WIN];
      else if (known[a % 256]) e_d = ram[a % 256];
      else chk_d = 0;
    end
    check("R2", int'(dq_oe), int'(e_oe));
    if (chk_d) check(cur_req, (^dq_out === 1'bx) ? -1 : int'(dq_out), e_d);
    @(posedge clk);
    model_step(c, w, a, d, tk, pf);
  endtask

  task automatic wr(int a, int d);          cyc(0, 1, 0, a, d, 0, 0); endtask
  task automatic rd(int a);                 cyc(0, 0, 1, a, 0, 0, 0); endtask
  task automatic tick();                    cyc(1, 1, 1, 0, 0, 1, 0); endtask
  task automatic read_win();
    for (int i = 0; i < 8; i++) rd(WIN + i);
  endtask

  task automatic set_time(int cent, int yr, int mo, int dt, int wd, int hr, int mi, int se);
    wr(WIN, 8'h40);
    wr(WIN + 1, to_bcd(se)); wr(WIN + 2, to_bcd(mi)); wr(WIN + 3, to_bcd(hr));
    wr(WIN + 4, cent * 64 + wd); wr(WIN + 5, to_bcd(dt));
    wr(WIN + 6, to_bcd(mo)); wr(WIN + 7, to_bcd(yr));
    wr(WIN, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R5 reset values
    cur_req = "R5"; read_win();

    // R1 R3 byte store, aliasing, oe_n ignored on write
    cur_req = "R1";
    wr(13'h0010, 8'hA5); cyc(0, 0, 0, 13'h0123, 8'h3C, 0, 0);
    rd(13'h0010); rd(13'h0023); rd(13'h1F23);
    cur_req = "R3"; wr(13'h1FF7, 8'h77); rd(13'h00F7);
    // R2 released cases
    cyc(0, 1, 1, 13'h0010, 0, 0, 0); cyc(1, 0, 1, 13'h0010, 0, 0, 0);

    // R6 R9 basic counting and refresh
    cur_req = "R9"; tick(); read_win();
    cur_req = "R6"; set_time(0, 24, 6, 15, 7, 23, 59, 58); tick(); read_win(); tick(); read_win();

    // R7 month ends and leap
    cur_req = "R7";
    set_time(0, 24, 2, 28, 3, 23, 59, 59); tick(); read_win(); // leap -> Feb 29
    set_time(0, 24, 2, 29, 3, 23, 59, 59); tick(); read_win(); // -> Mar 1
    set_time(0, 23, 2, 28, 3, 23, 59, 59); tick(); read_win(); // -> Mar 1
    set_time(0, 0, 2, 28, 3, 23, 59, 59); tick(); read_win();  // 00 leap
    set_time(0, 21, 4, 30, 3, 23, 59, 59); tick(); read_win();
    set_time(0, 21, 1, 31, 3, 23, 59, 59); tick(); read_win();

    // R8 year and century
    cur_req = "R8";
    set_time(1, 99, 12, 31, 7, 23, 59, 59); tick(); read_win();
    set_time(3, 99, 12, 31, 2, 23, 59, 59); tick(); read_win();

    // R10 freeze
    cur_req = "R10";
    wr(WIN, 8'h80); tick(); tick(); read_win();
    wr(WIN, 8'h00); read_win(); tick(); read_win();

    // R11 write mode gating, suspended refresh, tick dropped on load
    cur_req = "R11";
    wr(WIN + 1, 8'h33); read_win();
    wr(WIN, 8'h40); tick(); read_win();
    wr(WIN + 2, 8'h45); read_win();
    cyc(0, 1, 0, WIN, 8'h00, 1, 0); tick(); read_win();

    // R4 power fail blocks writes, time runs
    cur_req = "R4";
    cyc(0, 1, 0, 13'h0010, 8'h11, 0, 1); cyc(0, 1, 0, WIN, 8'h80, 0, 1);
    cyc(1, 1, 1, 0, 0, 1, 1); read_win(); rd(13'h0010);
    cyc(0, 1, 0, WIN, 8'h40, 0, 1); read_win();

    // R12 calibration value
    cur_req = "R12";
    wr(WIN, 8'h2A); rd(WIN); tick(); read_win();
    wr(WIN, 8'h15); tick(); tick(); read_win();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule